// File: doc/BRIEF.md
# Reset strap capture and mode decoder

This block reads a set of dual-purpose configuration pins while the active-low hardware reset is held. Five pins carry a device address and three carry the auto-negotiation setup. The values present at the last rising clock edge before reset is released are kept, and the three negotiation straps are turned into the power-up contents of a basic control register and an ability advertisement register.

A captured address of zero puts the data interface into isolation until the next hardware reset. The strap pins become LED outputs once capture is over, so the block drives their output enables. The enables stay low for a guard period after release to avoid contention.

After reset, a plain write strobe with a register index and a 16-bit word lets management logic rewrite the control register, the advertisement abilities and the address. None of these writes can enter or leave isolation.

Top module: `strap_capture_cfg`

## Requirements
- R1: Sampling is level-based. `phy_addr_o` holds the value of `addr_strap_i` at the last rising edge of `clk` with `rst_n` low, and any value from 0 to 31 is kept unchanged.
- R2: `isolate_o` is 1 exactly when the captured address is 0. It holds that value from release until the next hardware reset.
- R3: Writing any value, including 0, to the address field through the write port never changes `isolate_o`.
- R4: With `an_en_strap_i` = 0 (forced mode), the control register after capture has bit 12 = 0, bit 13 (speed, 1 = 100 Mb/s) = `an_sel_strap_i[1]`, bit 8 (duplex, 1 = full) = `an_sel_strap_i[0]`, and all other bits 0. So the codes are: 00 = 10 half, 01 = 10 full, 10 = 100 half, 11 = 100 full.
- R5: With `an_en_strap_i` = 1, the control register after capture has bit 12 = 1 and every other bit 0.
- R6: The advertisement ability bits are bit 5 = 10 half, bit 6 = 10 full, bit 7 = 100 half and bit 8 = 100 full.
  - With negotiation enabled, `an_sel_strap_i` 00 sets bits 5,6; 01 sets bits 7,8; 10 sets bits 5,7; 11 sets bits 5 to 8.
  - In forced mode, only the single bit of the forced ability is set.
  - Bits 15:9 are 0 after capture.
- R7: Bits 4:0 of `adv_reg_o` always read 00001, including after a write to the advertisement register.
- R8: Every bit of `pin_oe_o` is 0 while `rst_n` is low and after the first rising edge with `rst_n` high. All bits are 1 from the second such edge onward.
- R9: Writes with `wr_en_i` = 1 take effect at the next rising edge.
  - Index 0 loads the whole control word.
  - Index 4 loads advertisement bits 15:5.
  - Index 25 loads the address from data bits 4:0.
  - Any other index changes no output.
- R10: Writes presented while `rst_n` is low are ignored. Pin values seen at earlier edges of a reset period have no effect on the captured state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hardware reset; straps are sampled while it is low |
| addr_strap_i | input | 5 | Address strap pins |
| an_en_strap_i | input | 1 | Auto-negotiation enable strap |
| an_sel_strap_i | input | 2 | Mode select straps (bit 1 speed / bit 0 duplex in forced mode) |
| wr_en_i | input | 1 | Register write strobe |
| wr_idx_i | input | 5 | Register index of the write |
| wr_data_i | input | 16 | Write data |
| ctrl_reg_o | output | 16 | Basic control register |
| adv_reg_o | output | 16 | Advertisement register |
| phy_addr_o | output | 5 | Current device address |
| isolate_o | output | 1 | Interface isolation flag |
| pin_oe_o | output | 8 | Output enables of the eight strap pins |

## Verification
The bench walks all 32 addresses against all 8 negotiation codes. In each reset period it first presents the inverted straps and a write, then the real straps. A design that latched on the first reset edge, or that honoured writes during reset, would show the wrong word straight after release.

After each release the bench writes address 0. A design that derived isolation from the live address field would raise the flag. It then writes all ones to the advertisement register, which exposes a selector field that is not protected. A write to an unused index catches decoders that alias indices.

The output enables are compared every cycle. This shows up a design that opens the pins at the release edge and leaves out the guard clock.

// File: rtl/strapcfg_pkg.sv
package strapcfg_pkg;
   localparam int CTL_ANEG_BIT = 12;
   localparam int CTL_SPD_BIT  = 13;
   localparam int CTL_DPX_BIT  = 8;
   localparam int ADV_ABIL_LSB = 5;
   localparam int ADV_SEL_W    = 5;
   localparam logic [ADV_SEL_W-1:0] ADV_SEL_CODE = 5'b00001;

   // abil[0]=10 half, [1]=10 full, [2]=100 half, [3]=100 full
   typedef struct packed {
      logic       aneg;
      logic       spd;
      logic       dpx;
      logic [3:0] abil;
   } strap_dec_t;
endpackage

// File: rtl/strap_decoder.sv
module strap_decoder
   import strapcfg_pkg::*;
(
   input  logic       an_en_i,
   input  logic [1:0] an_sel_i,
   output strap_dec_t dec_o
);
   always_comb begin
      dec_o      = '0;
      dec_o.aneg = an_en_i;
      if (!an_en_i) begin
         dec_o.spd  = an_sel_i[1];
         dec_o.dpx  = an_sel_i[0];
         dec_o.abil = 4'b0001 << an_sel_i;
      end else begin
         unique case (an_sel_i)
            2'b00:   dec_o.abil = 4'b0011;
            2'b01:   dec_o.abil = 4'b1100;
            2'b10:   dec_o.abil = 4'b0101;
            default: dec_o.abil = 4'b1111;
         endcase
      end
   end

   always_comb begin
      if (!$isunknown({an_en_i, an_sel_i}) && !an_en_i)
         AST_FORCED_ONE_ABIL: assert ($countones(dec_o.abil) == 1); // R6
   end
endmodule

// File: rtl/strap_oe_gate.sv
module strap_oe_gate #(
   parameter int GUARD = 1,
   parameter int NPINS = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   output logic [NPINS-1:0] oe_o
);
   localparam int LAST = GUARD + 1;
   localparam int CW   = $clog2(LAST + 1);

   logic open_q;

   if (GUARD < 0) begin : g_bad_guard
      $error("strap_oe_gate: GUARD must be non-negative");
   end

   if (GUARD == 0) begin : g_direct
      always_ff @(posedge clk) begin
         if (!rst_n) open_q <= 1'b0;
         else        open_q <= 1'b1;
      end
   end else begin : g_counted
      logic [CW-1:0] cnt_q;
      always_ff @(posedge clk) begin
         if (!rst_n)
            cnt_q <= '0;
         else if (cnt_q != CW'(LAST))
            cnt_q <= cnt_q + 1'b1;
      end
      assign open_q = (cnt_q == CW'(LAST));
   end

   assign oe_o = {NPINS{open_q}};

   AST_OE_AFTER_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      oe_o[0] |-> $past(rst_n)); // R8
endmodule

// File: rtl/cfg_regs.sv
module cfg_regs
   import strapcfg_pkg::*;
#(
   parameter int DATA_W   = 16,
   parameter int IDX_W    = 5,
   parameter int ADDR_W   = 5,
   parameter int CTRL_IDX = 0,
   parameter int ADV_IDX  = 4,
   parameter int PCTL_IDX = 25
) (
   input  logic              clk,
   input  logic              rst_n,
   input  strap_dec_t        dec_i,
   input  logic [ADDR_W-1:0] strap_addr_i,
   input  logic              wr_en_i,
   input  logic [IDX_W-1:0]  wr_idx_i,
   input  logic [DATA_W-1:0] wr_data_i,
   output logic [DATA_W-1:0] ctrl_o,
   output logic [DATA_W-1:0] adv_o,
   output logic [ADDR_W-1:0] addr_o,
   output logic              iso_o
);
   localparam int AB_W = DATA_W - ADV_SEL_W;

   if (DATA_W < 16) begin : g_bad_width
      $error("cfg_regs: DATA_W must hold bit 13");
   end
   if (ADDR_W > DATA_W) begin : g_bad_addr
      $error("cfg_regs: address wider than data word");
   end

   logic [DATA_W-1:0] ctrl_init, adv_init;
   logic [DATA_W-1:0] ctrl_q;
   logic [AB_W-1:0]   adv_ab_q;
   logic [ADDR_W-1:0] addr_q;
   logic              iso_q;
   logic              hit_ctrl, hit_adv, hit_pctl;

   always_comb begin
      ctrl_init               = '0;
      ctrl_init[CTL_ANEG_BIT] = dec_i.aneg;
      ctrl_init[CTL_SPD_BIT]  = dec_i.spd;
      ctrl_init[CTL_DPX_BIT]  = dec_i.dpx;
      adv_init                = '0;
      adv_init[ADV_ABIL_LSB +: 4] = dec_i.abil;
   end

   assign hit_ctrl = wr_en_i && (wr_idx_i == IDX_W'(CTRL_IDX));
   assign hit_adv  = wr_en_i && (wr_idx_i == IDX_W'(ADV_IDX));
   assign hit_pctl = wr_en_i && (wr_idx_i == IDX_W'(PCTL_IDX));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_q   <= ctrl_init;
         adv_ab_q <= adv_init[DATA_W-1:ADV_SEL_W];
         addr_q   <= strap_addr_i;
         iso_q    <= (strap_addr_i == '0);
      end else begin
         if (hit_ctrl) ctrl_q   <= wr_data_i;
         if (hit_adv)  adv_ab_q <= wr_data_i[DATA_W-1:ADV_SEL_W];
         if (hit_pctl) addr_q   <= wr_data_i[ADDR_W-1:0];
      end
   end

   assign ctrl_o = ctrl_q;
   assign adv_o  = {adv_ab_q, ADV_SEL_CODE};
   assign addr_o = addr_q;
   assign iso_o  = iso_q;

   AST_CTRL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      hit_ctrl |=> ctrl_o == $past(wr_data_i)); // R9
   AST_ADDR_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      hit_pctl |=> addr_o == $past(wr_data_i[ADDR_W-1:0])); // R9
   AST_ADV_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      hit_adv |=> (adv_o[ADV_SEL_W-1:0] == ADV_SEL_CODE) &&
                  (adv_o[DATA_W-1:ADV_SEL_W] == $past(wr_data_i[DATA_W-1:ADV_SEL_W]))); // R7
   AST_ISO_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> $stable(iso_o)); // R3
endmodule

// File: rtl/strap_capture_cfg.sv
module strap_capture_cfg
   import strapcfg_pkg::*;
#(
   parameter int ADDR_W   = 5,
   parameter int DATA_W   = 16,
   parameter int IDX_W    = 5,
   parameter int OE_GUARD = 1,
   parameter int CTRL_IDX = 0,
   parameter int ADV_IDX  = 4,
   parameter int PCTL_IDX = 25
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [ADDR_W-1:0]     addr_strap_i,
   input  logic                  an_en_strap_i,
   input  logic [1:0]            an_sel_strap_i,
   input  logic                  wr_en_i,
   input  logic [IDX_W-1:0]      wr_idx_i,
   input  logic [DATA_W-1:0]     wr_data_i,
   output logic [DATA_W-1:0]     ctrl_reg_o,
   output logic [DATA_W-1:0]     adv_reg_o,
   output logic [ADDR_W-1:0]     phy_addr_o,
   output logic                  isolate_o,
   output logic [ADDR_W+2:0]     pin_oe_o
);
   localparam int NPINS = ADDR_W + 3;

   if (PCTL_IDX >= (1 << IDX_W) || ADV_IDX >= (1 << IDX_W) || CTRL_IDX >= (1 << IDX_W))
   begin : g_bad_idx
      $error("strap_capture_cfg: register index out of range");
   end

   strap_dec_t dec;

   strap_decoder u_dec (
      .an_en_i  (an_en_strap_i),
      .an_sel_i (an_sel_strap_i),
      .dec_o    (dec)
   );

   cfg_regs #(
      .DATA_W   (DATA_W),
      .IDX_W    (IDX_W),
      .ADDR_W   (ADDR_W),
      .CTRL_IDX (CTRL_IDX),
      .ADV_IDX  (ADV_IDX),
      .PCTL_IDX (PCTL_IDX)
   ) u_regs (
      .clk          (clk),
      .rst_n        (rst_n),
      .dec_i        (dec),
      .strap_addr_i (addr_strap_i),
      .wr_en_i      (wr_en_i),
      .wr_idx_i     (wr_idx_i),
      .wr_data_i    (wr_data_i),
      .ctrl_o       (ctrl_reg_o),
      .adv_o        (adv_reg_o),
      .addr_o       (phy_addr_o),
      .iso_o        (isolate_o)
   );

   strap_oe_gate #(
      .GUARD (OE_GUARD),
      .NPINS (NPINS)
   ) u_oe (
      .clk   (clk),
      .rst_n (rst_n),
      .oe_o  (pin_oe_o)
   );

   AST_ISO_ONLY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(rst_n) && isolate_o) |-> (phy_addr_o == '0)); // R2
endmodule

// File: tb/sim_strap_capture_cfg.sv
module sim_strap_capture_cfg;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [4:0]  addr_strap = '0;
   logic        an_en = 1'b1;
   logic [1:0]  an_sel = 2'b11;
   logic        wr_en = 1'b0;
   logic [4:0]  wr_idx = '0;
   logic [15:0] wr_data = '0;
   logic [15:0] ctrl_reg, adv_reg;
   logic [4:0]  phy_addr;
   logic        isolate;
   logic [7:0]  pin_oe;

   always #4 clk = ~clk;

   strap_capture_cfg u0 (
      .clk (clk), .rst_n (rst_n),
      .addr_strap_i (addr_strap), .an_en_strap_i (an_en), .an_sel_strap_i (an_sel),
      .wr_en_i (wr_en), .wr_idx_i (wr_idx), .wr_data_i (wr_data),
      .ctrl_reg_o (ctrl_reg), .adv_reg_o (adv_reg), .phy_addr_o (phy_addr),
      .isolate_o (isolate), .pin_oe_o (pin_oe)
   );

   int n_cmp = 0, n_bad = 0;
   bit finished = 0;

   // reference model, advanced at each rising edge from the driven inputs
   bit          m_valid = 0;
   logic [4:0]  m_addr;
   logic        m_iso;
   logic [15:0] m_ctrl, m_adv;
   int          m_cnt;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_valid = 1;
         m_addr  = addr_strap;
         m_iso   = (addr_strap == 5'd0);
         m_ctrl  = 16'h0000;
         m_adv   = 16'h0001;
         m_cnt   = 0;
         if (an_en) begin
            m_ctrl[12] = 1'b1;
            case (an_sel)
               2'b00: m_adv = m_adv | 16'h0060;
               2'b01: m_adv = m_adv | 16'h0180;
               2'b10: m_adv = m_adv | 16'h00A0;
               default: m_adv = m_adv | 16'h01E0;
            endcase
         end else begin
            m_ctrl[13] = an_sel[1];
            m_ctrl[8]  = an_sel[0];
            m_adv[5 + int'(an_sel)] = 1'b1;
         end
      end else begin
         if (m_cnt < 2) m_cnt++;
         if (wr_en) begin
            if (wr_idx == 5'd0)       m_ctrl = wr_data;
            else if (wr_idx == 5'd4)  m_adv  = {wr_data[15:5], 5'b00001};
            else if (wr_idx == 5'd25) m_addr = wr_data[4:0];
         end
      end
   end

   task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s at %0t: actual=%h expected=%h", tag, $time, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (m_valid && !finished) begin
         chk("R1 R9 R10 address", {11'd0, phy_addr}, {11'd0, m_addr});
         chk("R2 R3 isolate", {15'd0, isolate}, {15'd0, m_iso});
         chk("R4 R5 R9 R10 control", ctrl_reg, m_ctrl);
         chk("R6 R7 R9 advertisement", adv_reg, m_adv);
         chk("R8 output enables", {8'd0, pin_oe}, (m_cnt >= 2) ? 16'h00FF : 16'h0000);
      end
   end

   task automatic step();
      @(posedge clk);
      #2;
   endtask

   task automatic run_combo(input logic [4:0] a, input logic [2:0] c);
      // R10: inverted straps and a write first, real straps on the last reset edge
      rst_n = 1'b0;
      addr_strap = ~a; an_en = ~c[2]; an_sel = ~c[1:0];
      wr_en = 1'b1; wr_idx = 5'd0; wr_data = 16'hFFFF;
      step();
      addr_strap = a; an_en = c[2]; an_sel = c[1:0];
      wr_idx = 5'd25; wr_data = 16'h001F;
      step();
      rst_n = 1'b1;
      addr_strap = ~a; an_en = ~c[2]; an_sel = ~c[1:0];
      wr_en = 1'b0;
      step();
      wr_en = 1'b1; wr_idx = 5'd25; wr_data = 16'h0000;  // R3 write address 0
      step();
      wr_idx = 5'd4; wr_data = 16'hFFFF;                  // R7 selector protected
      step();
      wr_idx = 5'd7; wr_data = 16'h1234;                  // R9 unused index
      step();
      wr_idx = 5'd0; wr_data = 16'hA5A5;                  // R9 control write
      step();
      wr_en = 1'b0;
      step();
   endtask

   task automatic summary();
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   initial begin
      step();
      for (int a = 0; a < 32; a++)
         for (int c = 0; c < 8; c++)
            run_combo(5'(a), 3'(c));
      step();
      summary();
   end

   initial begin
      repeat (60000) @(posedge clk);
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog R1: actual=running expected=finished");
      summary();
   end
endmodule